// File: doc/BRIEF.md
# Line Clamp Pulse Generator

This block times two per-line events in a video digitizer from the pixel clock and the raw horizontal sync. Each falling edge of the sync input, which is the trailing edge of an active-high sync pulse, restarts a pixel counter. When the count reaches a programmed start pixel, the block raises a one-clock black-level sample strobe. On the same clock it opens a clamp-enable window of a programmed width. The clamp window drives the DC-restore switch for AC-coupled inputs.

The start pixel is 14 bits wide and arrives as two bytes. The upper byte carries 6 bits and the lower byte 8 bits. The clamp width is one byte. Both values are latched at each trailing edge, so a host may rewrite them at any time without corrupting the line in progress. A width of zero turns the clamp off completely, and the black-level strobe still fires.

Top module: `line_clamp_gen`

## Requirements
- R1: While reset is low, both outputs are low. The captured start pixel resets to 2 and the captured width resets to 16. The interval that begins when reset is released counts as a line using these values.
- R2: A trailing edge is a rising clock edge at which `hsync_raw` is 0 and was 1 at the previous rising edge. Suppose a trailing edge is sampled at edge T with captured start S. Then `blk_stb` is high during the one clock cycle that follows edge T+S+1, and low at all other times in that line.
- R3: The start pixel is `{start_hi, start_lo}`, with `start_hi` supplying bits 13:8 and `start_lo` supplying bits 7:0.
- R4: With captured width W > 0, `clamp_en` is high during the W consecutive cycles that follow edges T+S+1 through T+S+W, and low otherwise.
- R5: With a captured width of 0, `clamp_en` stays low for the whole line while `blk_stb` still fires as in R2.
- R6: A trailing edge sampled while the clamp window is open closes it from that edge on and restarts the count. A line that ends before edge T+S+1 produces no strobe.
- R7: Start and width are captured only at trailing edges and at reset. Changing the inputs mid-line does not move or resize the current line's pulses.
- R8: At most one strobe occurs per line, including when the start pixel is the largest 14-bit value and the counter saturates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_raw | input | 1 | Raw horizontal sync, active high |
| start_hi | input | 6 | Start pixel, upper bits |
| start_lo | input | 8 | Start pixel, lower byte |
| clamp_width | input | 8 | Clamp window length in pixels, 0 disables it |
| clamp_en | output | 1 | DC-restore clamp enable |
| blk_stb | output | 1 | Black-level sample strobe |

## Verification
The bench sweeps a grid of start pixels, clamp widths and line lengths. Some lines outlast the window, some cut it short, and some end before the start pixel is reached. This separates correct window placement from truncation by the next sync edge and from a missing strobe. Zero-width lines show whether the strobe is decoupled from the clamp. A line whose start is carried in the upper byte checks that the two bytes are assembled correctly. A maximum start value on a very long line checks the saturated count. Configuration rewrites in the middle of a line show whether values are latched only at the trailing edge.

// File: rtl/line_clamp_gen.sv
module line_clamp_gen #(
  parameter int HI_W  = 6,
  parameter int LO_W  = 8,
  parameter int WID_W = 8,
  parameter int START_RST = 2,
  parameter int WIDTH_RST = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_raw,
  input  logic [HI_W-1:0]  start_hi,
  input  logic [LO_W-1:0]  start_lo,
  input  logic [WID_W-1:0] clamp_width,
  output logic             clamp_en,
  output logic             blk_stb
);
  localparam int CNT_W = HI_W + LO_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             hs_q, fired;
  logic [CNT_W-1:0] cnt, start_r;
  logic [WID_W-1:0] width_r, rem;
  logic             trail, hit;

  assign trail    = hs_q & ~hsync_raw;
  assign hit      = ~trail & ~fired & (cnt == start_r);
  assign clamp_en = (rem != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q    <= 1'b0;
      cnt     <= '0;
      fired   <= 1'b0;
      start_r <= CNT_W'(START_RST);
      width_r <= WID_W'(WIDTH_RST);
      rem     <= '0;
      blk_stb <= 1'b0;
    end else begin
      hs_q    <= hsync_raw;
      blk_stb <= hit;
      if (trail) begin
        cnt     <= '0;
        fired   <= 1'b0;
        start_r <= {start_hi, start_lo};
        width_r <= clamp_width;
        rem     <= '0;
      end else begin
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        if (hit) begin
          fired <= 1'b1;
          rem   <= width_r;
        end else if (rem != '0) begin
          rem <= rem - 1'b1;
        end
      end
    end
  end

  // R8
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_stb |=> !blk_stb);

  // R4
  clamp_opens_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clamp_en) |-> blk_stb);

  // R4
  clamp_contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_en && !blk_stb) |-> $past(clamp_en));

  // R5
  zero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && width_r == '0) |=> !clamp_en);

  // R6
  trail_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trail |=> (!clamp_en && !blk_stb));
endmodule

// File: tb/line_clamp_gen_tb.sv
module line_clamp_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync = 1'b0;
  logic [5:0] s_hi = 6'd0;
  logic [7:0] s_lo = 8'd0;
  logic [7:0] wd = 8'd0;
  logic       clamp_en, blk_stb;

  int  cyc = 0, tl = 0, sc = 2, wc = 16;
  bit  ph = 1'b0;
  int  vecs = 0, bad = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  line_clamp_gen dut_i (
    .clk(clk), .rst_n(rst_n), .hsync_raw(hsync),
    .start_hi(s_hi), .start_lo(s_lo), .clamp_width(wd),
    .clamp_en(clamp_en), .blk_stb(blk_stb)
  );

  // reference timeline: latest line start and its captured config (R1 R3 R7)
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      tl = cyc; sc = 2; wc = 16; ph = 1'b0;
    end else begin
      if (ph && !hsync) begin
        tl = cyc; sc = {s_hi, s_lo}; wc = wd;
      end
      ph = hsync;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      bit es, ec;
      es = (cyc == tl + 1 + sc);
      ec = (cyc >= tl + 1 + sc) && (cyc <= tl + sc + wc);
      if (!rst_n) begin es = 1'b0; ec = 1'b0; end
      vecs++;
      if (blk_stb !== es) begin
        bad++;
        $display("FAIL R2 R8 strobe cyc=%0d S=%0d got=%b exp=%b", cyc, sc, blk_stb, es);
      end
      vecs++;
      if (clamp_en !== ec) begin
        bad++;
        $display("FAIL %s clamp cyc=%0d S=%0d W=%0d got=%b exp=%b",
                 (wc == 0) ? "R5" : "R4 R6", cyc, sc, wc, clamp_en, ec);
      end
    end
  end

  task automatic line(input int hi_len, input int lo_len);
    hsync = 1'b1;
    repeat (hi_len) @(negedge clk);
    hsync = 1'b0;
    repeat (lo_len) @(negedge clk);
  endtask

  task automatic cfg(input int s, input int w);
    s_hi = 6'(s >> 8); s_lo = 8'(s); wd = 8'(w);
  endtask

  initial begin
    int svals[6] = '{0, 1, 2, 3, 6, 9};
    int wvals[5] = '{0, 1, 2, 4, 13};
    int lvals[3] = '{4, 12, 25};
    repeat (5) @(negedge clk);  // R1 outputs low in reset
    rst_n = 1'b1;
    repeat (40) @(negedge clk); // R1 default start 2 width 16
    // R2 R4 R5 R6 sweep
    foreach (svals[i]) foreach (wvals[j]) foreach (lvals[k]) begin
      cfg(svals[i], wvals[j]);
      line(2, lvals[k]);
    end
    // R7 mid-line rewrites
    for (int n = 0; n < 20; n++) begin
      cfg(n % 7, (n * 3) % 11);
      hsync = 1'b1;
      repeat (1 + n % 3) @(negedge clk);
      hsync = 1'b0;
      repeat (3) @(negedge clk);
      cfg(13 - n % 5, 255 - n);
      repeat (15) @(negedge clk);
    end
    // R3 upper byte used
    cfg(259, 255);
    line(1, 600);
    line(1, 200);
    // R8 max start with saturated counter
    cfg(16383, 3);
    line(2, 16500);
    cfg(4, 5);
    line(2, 30);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++;
      $display("FAIL watchdog R1 got=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule